// File: doc/BRIEF.md
# Buffered SPI burst host

This block is an SPI host that moves a whole transaction in one go. Software fills an internal command buffer of up to 320 bytes over a 32-bit register port. It then writes one control word that carries the byte count, a coded clock speed, the SPI mode, the target device and a start bit. The block shifts the bytes out on MOSI and stores every byte it receives on MISO into a response buffer at the same index. It then flags completion in an event register that can raise an interrupt.

The bus port is a plain single-cycle word write port with a combinational read path. Reads have no side effects. Seven active-low chip selects are decoded from a 3-bit device field. A force bit keeps the selected device's chip select asserted between bursts, so that a multi-burst transaction stays framed.

Top module: `spi_burst_host`

## Requirements
- R1: After reset all chip selects are high, SCLK and MOSI are 0 and the interrupt is low. The control and event words read 0 and the event mask word reads 0x100.
- R2: The command buffer occupies byte addresses 0x000-0x13F and the response buffer 0x200-0x33F. Buffer words hold bytes little-endian: byte index 4w+k sits in bits 8k+7:8k of the word at offset 4w. Addresses 0x140-0x1FF and 0x340-0x3FF read 0.
- R3: The control word at 0x400 holds the device in bits 27:25, the byte count in bits 16:8, the speed code in bits 7:5, force chip select in bit 4, mode in bit 2 (1 = mode 3) and start in bit 0. These fields read back as written, except that a count above 320 reads back as 320.
- R4: Writing the control word with bit 0 set and a non-zero count starts a burst. MOSI carries the command bytes in index order, each most significant bit first. Bit 0 of the control word reads 1 while the burst runs.
- R5: The byte received during burst byte i lands in response byte i. Each MISO bit is taken at the leading SCLK edge.
- R6: With speed code c (codes 0 and 1 act as 2), every bit lasts c clock cycles. SCLK sits at its idle level for floor(c/2) cycles and then at the active level for the rest. The idle level is 0 in mode 0 and 1 in mode 3, and SCLK holds it whenever no burst runs.
- R7: At the clock edge that ends the last bit, start bit 0 reads 0 again and event bit 8 at 0x420 becomes 1, 8·count·c cycles after the start write. A start with count 0 sets the event bit at the start write itself.
- R8: The interrupt output is high exactly while event bit 8 is 1 and mask bit 8 at 0x424 is 0.
- R9: Writing 1 to event bit 8 clears it, and writing 0 there leaves it unchanged.
- R10: Chip select d (0-6) is low while a burst to device d runs or while force is 1 with device d selected. Device code 7 selects none.
- R11: Writes to the control word or the command buffer during a burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 7 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
Bursts run in mode 0 at code 2, in mode 3 at code 7, at code 0, and at the odd code 3 over a full 320-byte buffer. These settings separate even from odd half-period splits, idle levels, the treatment of low codes, and index wrap or clamp errors at the buffer end. The model predicts SCLK, MOSI, chip selects and the interrupt on every clock. A behavioural target returns a changing byte stream, so a response stored at the wrong index or with the wrong bit order is caught. Other stimuli are a zero-byte start, writes made during a running burst, device code 7 under force, and event writes with bit 8 at 0 and at 1. These tell the ignored and edge cases apart from the normal path.

// File: rtl/spi_burst_host.sv
module spi_burst_host #(
  parameter int BUF_BYTES = 320,
  parameter int NCS       = 7,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [NCS-1:0] spi_cs_n,
  output logic          irq
);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int IW = $clog2(BUF_BYTES);
  localparam logic [AW-1:0] RSP_BASE  = AW'(12'h200);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(12'h400);
  localparam logic [AW-1:0] EVT_ADDR  = AW'(12'h420);
  localparam logic [AW-1:0] MASK_ADDR = AW'(12'h424);

  function automatic logic [2:0] eff_code(input logic [2:0] s);
    return (s < 3'd2) ? 3'd2 : s;
  endfunction

  logic [7:0] cmd_mem [BUF_BYTES];
  logic [7:0] rsp_mem [BUF_BYTES];

  logic [2:0]    dev, spd, bit_n, tcnt;
  logic [CW-1:0] cnt;
  logic          force_ce, mode3, busy, evt, msk, act;
  logic [IW-1:0] bidx;
  logic [7:0]    tx_sh, rx_sh;

  wire [2:0] cur_c  = eff_code(spd);
  wire [2:0] cur_lo = cur_c >> 1;
  wire [2:0] cur_hi = cur_c - cur_lo;
  wire [2:0] new_lo = eff_code(bus_wdata[7:5]) >> 1;

  wire [AW-1:0] rsp_rel = bus_addr - RSP_BASE;
  wire          in_cmd  = bus_addr < AW'(BUF_BYTES);
  wire          in_rsp  = (bus_addr >= RSP_BASE) && (rsp_rel < AW'(BUF_BYTES));
  wire [IW-1:0] cmd_off = {bus_addr[IW-1:2], 2'b00};
  wire [IW-1:0] rsp_off = {rsp_rel[IW-1:2], 2'b00};

  wire          wr_ctrl = bus_we && (bus_addr == CTRL_ADDR) && !busy;
  wire [8:0]    wcnt    = bus_wdata[16:8];
  wire [CW-1:0] cnt_new = (32'(wcnt) > BUF_BYTES) ? CW'(BUF_BYTES) : CW'(wcnt);

  always_ff @(posedge clk) begin
    if (bus_we && in_cmd && !busy)
      for (int k = 0; k < 4; k++) cmd_mem[cmd_off + IW'(k)] <= bus_wdata[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev <= '0; spd <= '0; cnt <= '0; force_ce <= 1'b0; mode3 <= 1'b0;
      busy <= 1'b0; evt <= 1'b0; msk <= 1'b1; act <= 1'b0;
      bidx <= '0; bit_n <= '0; tcnt <= '0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      if (bus_we && bus_addr == EVT_ADDR && bus_wdata[8]) evt <= 1'b0;
      if (bus_we && bus_addr == MASK_ADDR) msk <= bus_wdata[8];
      if (wr_ctrl) begin
        dev      <= bus_wdata[27:25];
        cnt      <= cnt_new;
        spd      <= bus_wdata[7:5];
        force_ce <= bus_wdata[4];
        mode3    <= bus_wdata[2];
        if (bus_wdata[0]) begin
          if (cnt_new == '0) evt <= 1'b1;
          else begin
            busy  <= 1'b1;
            bidx  <= '0;
            bit_n <= 3'd7;
            tx_sh <= cmd_mem[0];
            act   <= 1'b0;
            tcnt  <= new_lo - 3'd1;
          end
        end
      end else if (busy) begin
        if (tcnt != 3'd0) tcnt <= tcnt - 3'd1;
        else if (!act) begin
          act   <= 1'b1;
          rx_sh <= {rx_sh[6:0], spi_miso};
          tcnt  <= cur_hi - 3'd1;
        end else begin
          act  <= 1'b0;
          tcnt <= cur_lo - 3'd1;
          if (bit_n == 3'd0) begin
            rsp_mem[bidx] <= rx_sh;
            if (CW'(bidx) == cnt - CW'(1)) begin
              busy <= 1'b0;
              evt  <= 1'b1;
            end else begin
              bidx  <= bidx + IW'(1);
              tx_sh <= cmd_mem[bidx + IW'(1)];
              bit_n <= 3'd7;
            end
          end else begin
            bit_n <= bit_n - 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_cmd)
      for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = cmd_mem[cmd_off + IW'(k)];
    else if (in_rsp)
      for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = rsp_mem[rsp_off + IW'(k)];
    else if (bus_addr == CTRL_ADDR)
      bus_rdata = {4'b0, dev, 8'b0, 9'(cnt), spd, force_ce, 1'b0, mode3, 1'b0, busy};
    else if (bus_addr == EVT_ADDR)
      bus_rdata = {23'b0, evt, 8'b0};
    else if (bus_addr == MASK_ADDR)
      bus_rdata = {23'b0, msk, 8'b0};
  end

  assign spi_sclk = mode3 ^ (busy & act);
  assign spi_mosi = busy & tx_sh[7];
  assign irq      = evt & ~msk;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign spi_cs_n[i] = !((dev == 3'(i)) && (busy || force_ce));
  end

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_sclk == mode3);
  p_cs_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy && (32'(dev) < NCS) |-> $countones(~spi_cs_n) == 1);
  p_done_evt_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> evt);
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(cnt) && $stable(dev) && $stable(spd) && $stable(mode3));
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> CW'(bidx) < cnt);
endmodule

// File: tb/spi_burst_host_tb.sv
module spi_burst_host_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, irq;
  logic [6:0] spi_cs_n;

  spi_burst_host dut_i (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model
  bit [7:0] sh_cmd [320];
  int  m_dev = 0, m_cnt = 0, m_spd = 0, m_cyc = 0;
  bit  m_force = 0, m_mode = 0, m_busy = 0, m_evt = 0, m_msk = 1;

  function automatic int eff(input int s); return (s < 2) ? 2 : s; endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dev = 0; m_cnt = 0; m_spd = 0; m_force = 0; m_mode = 0;
      m_busy = 0; m_evt = 0; m_msk = 1; m_cyc = 0;
    end else begin
      if (bus_we && bus_addr < 12'd320 && !m_busy)
        for (int k = 0; k < 4; k++) sh_cmd[{bus_addr[8:2], 2'b00} + k] = bus_wdata[8*k +: 8];
      if (bus_we && bus_addr == 12'h420 && bus_wdata[8]) m_evt = 0;
      if (bus_we && bus_addr == 12'h424) m_msk = bus_wdata[8];
      if (bus_we && bus_addr == 12'h400 && !m_busy) begin
        m_dev = int'(bus_wdata[27:25]);
        m_cnt = int'(bus_wdata[16:8]);
        if (m_cnt > 320) m_cnt = 320;
        m_spd = int'(bus_wdata[7:5]);
        m_force = bus_wdata[4];
        m_mode = bus_wdata[2];
        if (bus_wdata[0]) begin
          if (m_cnt == 0) m_evt = 1;
          else begin m_busy = 1; m_cyc = 0; end
        end
      end else if (m_busy) begin
        m_cyc = m_cyc + 1;
        if (m_cyc == 8 * m_cnt * eff(m_spd)) begin m_busy = 0; m_evt = 1; end
      end
    end
  end

  // behavioural target
  bit [7:0] sbyte = 8'hA5;
  int  sk = 0, lead_n = 0;
  bit [7:0] sacc = 0;
  bit  prev_sclk = 0, prev_mode = 0;
  bit [7:0] sent_q[$], mosi_q[$];
  assign spi_miso = sbyte[3'(7 - sk)];

  always @(negedge clk) begin
    if (!rst && m_mode == prev_mode) begin
      if (prev_sclk == m_mode && spi_sclk != m_mode) begin
        if (sk == 0) sent_q.push_back(sbyte);
        sacc = {sacc[6:0], spi_mosi};
        lead_n++;
        if (lead_n == 8) begin mosi_q.push_back(sacc); lead_n = 0; end
      end else if (prev_sclk != m_mode && spi_sclk == m_mode) begin
        sk++;
        if (sk == 8) begin sk = 0; sbyte = sbyte * 8'd37 + 8'd11; end
      end
    end
    prev_sclk = spi_sclk;
    prev_mode = m_mode;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      int c, lo;
      bit exp_sclk, exp_mosi;
      bit [6:0] exp_cs;
      c = eff(m_spd);
      lo = c / 2;
      exp_sclk = m_mode ^ (m_busy && (m_cyc % c) >= lo);
      exp_mosi = m_busy ? sh_cmd[m_cyc / (8 * c)][7 - ((m_cyc / c) % 8)] : 1'b0;
      for (int i = 0; i < 7; i++) exp_cs[i] = !(i == m_dev && (m_busy || m_force));
      chk(spi_sclk == exp_sclk, "R6 sclk", spi_sclk, exp_sclk);
      chk(spi_mosi == exp_mosi, "R4 mosi", spi_mosi, exp_mosi);
      chk(spi_cs_n == exp_cs, "R10 cs_n", spi_cs_n, exp_cs);
      chk(irq == (m_evt && !m_msk), "R8 irq", irq, m_evt && !m_msk);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_we = 0; bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int dv, input int n, input int sp,
                                      input bit fc, input bit md, input bit go);
    return (32'(dv) << 25) | (32'(n) << 8) | (32'(sp) << 5) | (32'(fc) << 4) | (32'(md) << 2) | 32'(go);
  endfunction

  task automatic fill(input int seed);
    for (int w = 0; w < 80; w++) begin
      logic [31:0] d;
      for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'((4*w + k) * 7 + seed);
      wr(12'(4*w), d);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_burst(input int n, input string tag);
    logic [31:0] d;
    chk(sent_q.size() == n && mosi_q.size() == n, {tag, " R4 byte count"}, mosi_q.size(), n);
    for (int i = 0; i < n && i < sent_q.size() && i < mosi_q.size(); i++) begin
      if (i % 4 == 0) rd(12'h200 + 12'(i), d);
      chk(d[8*(i%4) +: 8] == sent_q[i], {tag, " R5 response byte"}, d[8*(i%4) +: 8], sent_q[i]);
      chk(mosi_q[i] == sh_cmd[i], {tag, " R4 mosi byte"}, mosi_q[i], sh_cmd[i]);
    end
    rd(12'h420, d);
    chk(d == 32'h100, {tag, " R7 event set"}, d, 32'h100);
    rd(12'h400, d);
    chk(d[0] == 1'b0, {tag, " R7 start cleared"}, d[0], 0);
  endtask

  task automatic start(input logic [31:0] w);
    sent_q.delete(); mosi_q.delete();
    wr(12'h400, w);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 7'h7F && spi_sclk == 0 && spi_mosi == 0 && irq == 0, "R1 pins", {spi_cs_n, spi_sclk, irq}, 8'hFC);
    rd(12'h400, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(12'h420, d); chk(d == 0, "R1 event", d, 0);
    rd(12'h424, d); chk(d == 32'h100, "R1 mask", d, 32'h100);

    // R2 buffer map
    fill(3);
    rd(12'h004, d); chk(d == {8'(7*7+3), 8'(6*7+3), 8'(5*7+3), 8'(4*7+3)}, "R2 little-endian", d, 0);
    rd(12'h13C, d); chk(d[31:24] == 8'(319*7+3), "R2 last word", d[31:24], 8'(319*7+3));
    rd(12'h140, d); chk(d == 0, "R2 beyond cmd", d, 0);
    rd(12'h340, d); chk(d == 0, "R2 beyond rsp", d, 0);

    // burst A: mode 0, code 2, device 1
    start(ctl(1, 4, 2, 0, 0, 1));
    rd(12'h400, d); chk(d[0] == 1'b1, "R4 start reads busy", d[0], 1);
    wait_idle();
    check_burst(4, "A");
    chk(irq == 0, "R8 masked", irq, 0);
    wr(12'h424, 32'h0);
    @(negedge clk); chk(irq == 1, "R8 unmasked", irq, 1);
    wr(12'h420, 32'h0);
    rd(12'h420, d); chk(d == 32'h100, "R9 write 0 keeps", d, 32'h100);
    wr(12'h420, 32'h100);
    rd(12'h420, d); chk(d == 0, "R9 write 1 clears", d, 0);

    // burst B: mode 3, code 7, device 6, forced hold; writes during burst
    start(ctl(6, 5, 7, 1, 1, 1));
    repeat (20) @(negedge clk);
    wr(12'h400, ctl(2, 9, 3, 0, 0, 1));
    wr(12'h000, 32'hDEADBEEF);
    wait_idle();
    check_burst(5, "B");
    rd(12'h400, d); chk(d == ctl(6, 5, 7, 1, 1, 0), "R11 R3 ctrl unchanged", d, ctl(6, 5, 7, 1, 1, 0));
    rd(12'h000, d); chk(d == {8'(3*7+3), 8'(2*7+3), 8'(1*7+3), 8'(3)}, "R11 cmd unchanged", d, 0);
    chk(spi_cs_n[6] == 0, "R10 forced hold", spi_cs_n[6], 0);
    wr(12'h420, 32'h100);

    // burst C: code 0 acts as 2
    start(ctl(6, 3, 0, 1, 0, 1));
    wait_idle();
    check_burst(3, "C");
    wr(12'h420, 32'h100);

    // zero count
    wr(12'h400, ctl(0, 0, 2, 0, 0, 1));
    rd(12'h420, d); chk(d == 32'h100, "R7 zero count event", d, 32'h100);
    rd(12'h400, d); chk(d[0] == 0, "R7 zero count idle", d[0], 0);
    wr(12'h420, 32'h100);

    // R3 clamp and full buffer at odd code
    wr(12'h400, ctl(0, 511, 3, 0, 0, 0));
    rd(12'h400, d); chk(d[16:8] == 9'd320, "R3 count clamp", d[16:8], 320);
    fill(91);
    start(ctl(0, 511, 3, 0, 0, 1));
    wait_idle();
    check_burst(320, "D");
    wr(12'h420, 32'h100);

    // device 7 selects none
    wr(12'h400, ctl(7, 1, 2, 1, 0, 0));
    @(negedge clk); chk(spi_cs_n == 7'h7F, "R10 device 7", spi_cs_n, 7'h7F);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule